// File: doc/BRIEF.md
# IO Coherency Aperture Decoder

The block classifies device (DMA) transactions by address. A transaction whose address falls inside one programmable aperture is marked coherent, so that the fabric can route it through the coherent path. All other transactions are marked non-coherent. The snoop machinery and the cache lookup sit elsewhere. This block only makes the decision.

Software sets up the aperture through a small register bus. A size code N selects an aperture of 2^(N+2) KB, so code 0 gives 4 KB, code 0x11 gives 512 MB and code 0x12 gives 1 GB. A base register holds the aperture start in 4 KB pages, and that start must be aligned to the aperture size. Two control bits must both be set before anything is classified as coherent. If the enable bit is set while the size and base disagree, the block raises a configuration-error flag. The same flag is raised for a size code too large for the address space. While the flag is up, the block marks every transaction non-coherent.

Transactions are presented as a 4 KB page number, because the offset within a page cannot affect the decision. The verdict appears on the clock after the transaction.

Top module: `coh_aperture_dec`

## Requirements
- R1: After a synchronous active-low reset, all three register fields read zero, and coh_valid, coherent and cfg_err are low.
- R2: A write takes effect at the clock edge where reg_we is high. The registers are selected by reg_addr:
  - offset 0 is control: bit 0 is enable and bit 1 is partial-coherency.
  - offset 1 is the size code, in bits [4:0].
  - offset 2 is the base page number, in bits [19:0].
  - offset 3 is reserved. Writes to it are dropped and it reads zero.
  - reg_rdata is a combinational read of the register at reg_addr, and unwritable bits read zero.
- R3: With a valid configuration, a transaction is coherent exactly when its byte address lies in [base*4096, base*4096 + 2^(N+12)).
- R4: coh_valid is high on the cycle after txn_valid is high, and low otherwise. coherent is low whenever coh_valid is low.
- R5: While the enable bit is clear, every transaction is non-coherent and cfg_err is low.
- R6: While the partial-coherency bit is clear, every transaction is non-coherent, even when enable is set.
- R7: With enable set, a base that has any of its low N bits nonzero (misaligned) raises cfg_err, and every transaction is then non-coherent.
- R8: With enable set, a size code above 20 (an aperture larger than the 32-bit space) raises cfg_err, and every transaction is then non-coherent.
- R9: A transaction presented in the same cycle as a register write is classified with the configuration in force before that write.
- R10: The boundaries are exact. The first and last pages of the aperture are coherent, and the pages just outside it are not. Code 20 with base 0 makes every page coherent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset for read and write |
| reg_wdata | input | 20 | Register write data |
| reg_rdata | output | 20 | Register read data (combinational) |
| txn_valid | input | 1 | Transaction present this cycle |
| txn_page | input | 20 | Transaction address bits [31:12] |
| coh_valid | output | 1 | Verdict present (one cycle after txn_valid) |
| coherent | output | 1 | Transaction lies in an active, legal aperture |
| cfg_err | output | 1 | Enabled configuration is illegal |

## Verification
coh_valid and coherent are due one clock after the transaction cycle. cfg_err and reg_rdata follow the registers combinationally, so they are due in the cycle after the write edge. The bench model updates its registers and computes the verdict at each rising edge, using the configuration from before the write. The design's outputs are then compared with the model at the following falling edge, which keeps the checks clear of the edge. Write data carries extra high bits to show that they are dropped, and a write and a transaction in the same cycle exercise the ordering rule.

// File: rtl/coh_apt_pkg.sv
// Shared definitions for the coherency aperture decoder.
// Assumes a 32-bit byte address split into a 20-bit page number and a 12-bit page offset.
package coh_apt_pkg;
    localparam int ADDR_W     = 32;
    localparam int PAGE_SHIFT = 12;
    localparam int PN_W       = ADDR_W - PAGE_SHIFT;
    localparam int CODE_W     = $clog2(PN_W + 1);

    typedef enum logic [1:0] {
        OFS_CTRL = 2'd0,
        OFS_SIZE = 2'd1,
        OFS_BASE = 2'd2,
        OFS_RSVD = 2'd3
    } reg_ofs_e;

    typedef struct packed {
        logic partial;
        logic enable;
    } ctrl_t;
endpackage

// File: rtl/coh_apt_regs.sv
// Register file: control bits, size code and base page number.
// Writes land on the clock edge; reads are combinational; reset is synchronous active-low.
module coh_apt_regs
    import coh_apt_pkg::*;
#(
    parameter int PW = PN_W,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [1:0]    addr,
    input  logic [PW-1:0] wdata,
    output logic [PW-1:0] rdata,
    output ctrl_t         ctrl,
    output logic [CW-1:0] code,
    output logic [PW-1:0] base
);
    // Purpose: store the fields written over the register bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            code <= '0;
            base <= '0;
        end else if (we) begin
            case (reg_ofs_e'(addr))
                OFS_CTRL: ctrl <= ctrl_t'(wdata[1:0]);
                OFS_SIZE: code <= wdata[CW-1:0];
                OFS_BASE: base <= wdata;
                default:  ;
            endcase
        end
    end

    // Purpose: read back the selected register, zero-extended.
    always_comb begin
        rdata = '0;
        case (reg_ofs_e'(addr))
            OFS_CTRL: rdata[1:0]    = ctrl;
            OFS_SIZE: rdata[CW-1:0] = code;
            OFS_BASE: rdata         = base;
            default:  rdata         = '0;
        endcase
    end
endmodule

// File: rtl/coh_apt_mask.sv
// Turns the size code into a per-bit mask of the page-number bits that must match the base.
// Assumes code N means 2^N pages; codes above PW are reported as out of range.
module coh_apt_mask #(
    parameter int PW = 20,
    parameter int CW = 5
) (
    input  logic [CW-1:0] code,
    output logic [PW-1:0] keep_mask,
    output logic          size_ok
);
    // Purpose: bit i takes part in the compare when it lies at or above the aperture size.
    for (genvar i = 0; i < PW; i++) begin : g_bit
        localparam logic [CW:0] IDX = (CW+1)'(i);
        assign keep_mask[i] = ({1'b0, code} <= IDX);
    end

    // Purpose: flag codes that describe an aperture larger than the address space.
    localparam logic [CW:0] MAX_CODE = (CW+1)'(PW);
    assign size_ok = ({1'b0, code} <= MAX_CODE);
endmodule

// File: rtl/coh_apt_match.sv
// Compares a transaction page with the base and produces the registered verdict and the error flag.
// Assumes the mask and range flag come from coh_apt_mask; the verdict is valid one cycle after txn_valid.
module coh_apt_match
    import coh_apt_pkg::*;
#(
    parameter int PW = PN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ctrl_t         ctrl,
    input  logic [PW-1:0] base,
    input  logic [PW-1:0] keep_mask,
    input  logic          size_ok,
    input  logic          txn_valid,
    input  logic [PW-1:0] txn_page,
    output logic          cfg_err,
    output logic          coh_valid,
    output logic          coherent
);
    logic misaligned;
    logic hit;
    logic active;

    // Purpose: detect illegal configurations and decide the match for this cycle.
    always_comb begin
        misaligned = |(base & ~keep_mask);
        cfg_err    = ctrl.enable && (misaligned || !size_ok);
        active     = ctrl.enable && ctrl.partial && !cfg_err;
        hit        = ((txn_page ^ base) & keep_mask) == '0;
    end

    // Purpose: register the verdict for the transaction seen this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coh_valid <= 1'b0;
            coherent  <= 1'b0;
        end else begin
            coh_valid <= txn_valid;
            coherent  <= txn_valid && active && hit;
        end
    end
endmodule

// File: rtl/coh_aperture_dec.sv
// Top level of the coherency aperture decoder: register file, size-mask generator and matcher.
// Assumes a single aperture; transactions arrive as 4 KB page numbers.
module coh_aperture_dec
    import coh_apt_pkg::*;
#(
    parameter int PW = PN_W,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [1:0]    reg_addr,
    input  logic [PW-1:0] reg_wdata,
    output logic [PW-1:0] reg_rdata,
    input  logic          txn_valid,
    input  logic [PW-1:0] txn_page,
    output logic          coh_valid,
    output logic          coherent,
    output logic          cfg_err
);
    ctrl_t         ctrl_q;
    logic [CW-1:0] code_q;
    logic [PW-1:0] base_q;
    logic [PW-1:0] keep_mask;
    logic          size_ok;
    logic          ctrl_en;

    assign ctrl_en = ctrl_q.enable;

    coh_apt_regs #(.PW(PW), .CW(CW)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ctrl  (ctrl_q),
        .code  (code_q),
        .base  (base_q)
    );

    coh_apt_mask #(.PW(PW), .CW(CW)) u_mask (
        .code      (code_q),
        .keep_mask (keep_mask),
        .size_ok   (size_ok)
    );

    coh_apt_match #(.PW(PW)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl_q),
        .base      (base_q),
        .keep_mask (keep_mask),
        .size_ok   (size_ok),
        .txn_valid (txn_valid),
        .txn_page  (txn_page),
        .cfg_err   (cfg_err),
        .coh_valid (coh_valid),
        .coherent  (coherent)
    );
endmodule

// File: rtl/coh_aperture_dec_chk.sv
// Checker for the coherency aperture decoder, bound to the top module.
module coh_aperture_dec_chk (
    input logic clk,
    input logic rst_n,
    input logic txn_valid,
    input logic coh_valid,
    input logic coherent,
    input logic cfg_err,
    input logic ctrl_en
);
    // R4
    verdict_follows_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |=> coh_valid);

    // R4
    no_spurious_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_valid |=> !coh_valid);

    // R4
    coherent_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        coherent |-> coh_valid);

    // R5
    disabled_not_coherent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> !coherent);

    // R5
    disabled_no_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> !cfg_err);

    // R7
    error_blocks_coherent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> !coherent);
endmodule

bind coh_aperture_dec coh_aperture_dec_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .txn_valid (txn_valid),
    .coh_valid (coh_valid),
    .coherent  (coherent),
    .cfg_err   (cfg_err),
    .ctrl_en   (ctrl_en)
);

// File: tb/coh_aperture_dec_test.sv
`timescale 1ns/100ps
module coh_aperture_dec_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [19:0] reg_wdata = '0;
    logic [19:0] reg_rdata;
    logic        txn_valid = 1'b0;
    logic [19:0] txn_page = '0;
    logic        coh_valid, coherent, cfg_err;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_req = "R1";
    bit    started = 0;
    int    cycles  = 0;

    // behavioural model state
    int    m_en = 0, m_part = 0, m_code = 0, m_base = 0;
    bit    e_cv = 0, e_coh = 0;

    always #2.5 clk = ~clk;

    coh_aperture_dec uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txn_valid(txn_valid),
        .txn_page(txn_page), .coh_valid(coh_valid), .coherent(coherent),
        .cfg_err(cfg_err)
    );

    function automatic bit m_err();
        longint size, start;
        if (m_en == 0) return 0;
        if (m_code > 20) return 1;
        size  = longint'(1) << (m_code + 12);
        start = longint'(m_base) << 12;
        return (start % size) != 0;
    endfunction

    function automatic bit m_hit(int page);
        longint size, start, a;
        if (m_en == 0 || m_part == 0 || m_err()) return 0;
        size  = longint'(1) << (m_code + 12);
        start = longint'(m_base) << 12;
        a     = longint'(page) << 12;
        return (a >= start) && (a < start + size);
    endfunction

    function automatic int m_rdata(int ofs);
        case (ofs)
            0: return m_en | (m_part << 1);
            1: return m_code;
            2: return m_base;
            default: return 0;
        endcase
    endfunction

    // model: verdict uses the configuration before any write at this edge
    always @(posedge clk) begin
        started = 1;
        cycles++;
        if (!rst_n) begin
            m_en = 0; m_part = 0; m_code = 0; m_base = 0;
            e_cv = 0; e_coh = 0;
        end else begin
            e_cv  = txn_valid;
            e_coh = txn_valid && m_hit(int'(txn_page));
            if (reg_we) begin
                case (reg_addr)
                    2'd0: begin m_en = int'(reg_wdata[0]); m_part = int'(reg_wdata[1]); end
                    2'd1: m_code = int'(reg_wdata) & 31;
                    2'd2: m_base = int'(reg_wdata);
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (started) begin
            chk("coh_valid", int'(coh_valid), int'(e_cv));
            chk("coherent",  int'(coherent),  int'(e_coh));
            chk("cfg_err",   int'(cfg_err),   int'(m_err()));
            chk("reg_rdata", int'(reg_rdata), m_rdata(int'(reg_addr)));
        end
    end

    task automatic finish_up();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        if (cycles > 100000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_up();
        end
    end

    task automatic step();
        @(posedge clk); #1;
        reg_we = 0; txn_valid = 0;
    endtask

    task automatic wr(int ofs, int val);
        reg_we = 1; reg_addr = 2'(ofs); reg_wdata = 20'(val);
        step();
    endtask

    task automatic rd(int ofs);
        reg_addr = 2'(ofs);
        step();
    endtask

    task automatic txn(longint byte_addr);
        txn_valid = 1; txn_page = 20'(byte_addr >> 12);
        step();
    endtask

    task automatic cfg(int code, int base_pg, int ctl);
        wr(1, code); wr(2, base_pg); wr(0, ctl);
    endtask

    initial begin
        #1;
        repeat (3) step();
        cur_req = "R1";
        for (int o = 0; o < 4; o++) rd(o);
        rst_n = 1;
        step();

        cur_req = "R2";
        wr(0, 20'hFFFFF); rd(0);
        wr(1, 20'hFFFF3); rd(1);
        wr(2, 20'hABCDE); rd(2);
        wr(3, 20'h12345); rd(3);
        wr(0, 0); rd(0);

        cur_req = "R3";
        cfg(0, 20'h00010, 3);
        txn(32'h0000_FFFF); txn(32'h0001_0000); txn(32'h0001_0FFF); txn(32'h0001_1000);
        cfg(5'h11, 20'h20000, 3);
        txn(32'h1FFF_FFFF); txn(32'h2000_0000); txn(32'h2ABC_0000);
        cfg(5'h12, 20'h40000, 3);
        txn(32'h3FFF_F000); txn(32'h4000_0000); txn(32'h7FFF_F000); txn(32'h8000_0000);

        cur_req = "R10";
        cfg(5'h11, 20'h20000, 3);
        txn(32'h3FFF_F000); txn(32'h4000_0000);
        cfg(20, 0, 3);
        txn(0); txn(32'hFFFF_F000); txn(32'h8000_0000);

        cur_req = "R4";
        txn_valid = 1; txn_page = 20'h12345; step();
        step(); step();
        txn(0); txn(32'h1234_5000);

        cur_req = "R5";
        cfg(20, 0, 2);
        txn(0); txn(32'h4000_0000);
        wr(2, 20'h00001); rd(0);

        cur_req = "R6";
        cfg(3, 20'h00008, 1);
        txn(32'h0000_8000); txn(32'h0000_F000);

        cur_req = "R7";
        cfg(5'h11, 20'h20100, 3);
        txn(32'h2010_0000); txn(32'h2000_0000);
        cfg(4, 20'h00018, 3);
        txn(32'h0001_8000);
        wr(0, 0); rd(0);

        cur_req = "R8";
        cfg(21, 0, 3);
        txn(0); txn(32'hFFFF_F000);
        cfg(31, 0, 3);
        txn(32'h8000_0000);

        cur_req = "R9";
        cfg(2, 20'h00004, 3);
        reg_we = 1; reg_addr = 2'd0; reg_wdata = 0;
        txn_valid = 1; txn_page = 20'h00004; step();
        txn(32'h0000_4000);
        reg_we = 1; reg_addr = 2'd0; reg_wdata = 3;
        txn_valid = 1; txn_page = 20'h00004; step();
        txn(32'h0000_4000);

        cur_req = "R3";
        for (int k = 0; k < 200; k++) begin
            if (k % 25 == 0) cfg(int'($urandom_range(0, 22)), int'($urandom) & 20'hFFFFF & ~((1 << (k % 21)) - 1), 3);
            txn(longint'($urandom));
        end

        step(); step();
        finish_up();
    end
endmodule